// File: doc/BRIEF.md
# Frame-Based SPI Master Engine

This block is an SPI master that moves whole frames of words. Software sets the serial format (clock polarity, clock phase, bit order, data-output release) and the frame shape (word length and word count). It then fills a transmit FIFO whose 32-bit entries hold each word left-justified, and raises four control enables one at a time. Once the serial clock, transmit and frame-start enables are all active, the engine shifts the programmed number of words on `sclk`/`mosi` and samples `miso`. Each received word goes into a receive FIFO, also left-justified. Two sticky end-of-frame flags can drive an interrupt.

Each control enable passes through a synchronizer before the engine acts on it. Reads of the control register return the synchronized copy, not the value last written. Software therefore confirms each step of the start and stop sequence by polling the readback. Chip select is driven outside the block.

Register offsets on the 32-bit bus: 0x00 format, 0x04 frame mode, 0x08 control, 0x0C status, 0x10 interrupt enable, 0x14 transmit data (a write pushes), 0x18 receive data (a read pops; reads as 0 when empty). Format register: bit 0 clock phase, bit 1 clock polarity, bit 2 data-output release, bit 24 LSB-first. Frame mode register: bits [28:24] word length minus one (8 to 32 bits), bits [23:16] word count minus one, bit 0 transmit-data disable.

Top module: `spi_frame_master`

## Requirements
- R1: A value written to the control register (bit 15 clock enable, bit 14 frame start, bit 9 transmit enable, bit 8 receive enable) reads back unchanged until SYNC_STAGES clock edges after the write. From then on the new value reads back.
- R2: A frame starts only while the synchronized clock, transmit and frame-start enables are all set. With frame start clear, `sclk` stays at its idle level and no status flag is set.
- R3: With LSB-first clear, each word of N bits is sent from entry bits [31:32-N], bit 31 first. Words are sent in FIFO order, and exactly N times the word count sampling edges occur per frame.
- R4: With LSB-first set (format bit 24), each word is sent starting at entry bit 32-N and ending at bit 31.
- R5: When receive is enabled, each received word is written to the receive FIFO left-justified, in the same bit order used for sending, with the low 32-N bits zero.
- R6: With transmit-data disable set (mode bit 0), `mosi` stays low for the whole frame and the transmit FIFO is neither read nor popped.
- R7: With receive disabled, a frame writes nothing into the receive FIFO and does not set the receive end-of-frame flag.
- R8: `sclk` idles at the clock polarity. Data changes at the start of each bit, and `miso` is sampled at mid-bit. With clock phase 0 the sampling edge is the first edge of the bit; with clock phase 1 it is the second edge.
- R9: The receive end-of-frame flag (status bit 7) is set when the last word enters the receive FIFO. The transmit end-of-frame flag (status bit 23) is set later, after the last bit has fully ended. Writing 1 to a flag clears it.
- R10: `irq` is high exactly when some status flag is set together with its enable at the same bit position of the interrupt enable register.
- R11: With data-output release set (format bit 2), `mosi_oe` is low whenever the engine is not driving data. Otherwise it stays high.
- R12: After a frame ends, no new frame starts until frame start has been cleared and set again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops receive FIFO at 0x18) |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| irq | output | 1 | Interrupt request |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| mosi_oe | output | 1 | Output enable for `mosi` |
| miso | input | 1 | Serial data in |

## Verification
The bench builds the block with a 16-deep FIFO, two synchronizer stages and a half-period of two core clocks. The shallow FIFO lets a full-depth frame of 32-bit words complete in a few thousand cycles. The short half-period puts the receive flag and the transmit flag only two cycles apart, which makes their relative order visible to per-cycle polling. Two synchronizer stages leave a readback window that one read inside the lag can observe. A slave model in the bench samples `mosi` and drives `miso` on the edges its mode dictates, so all four clock modes, both bit orders and word lengths from 8 to 32 are reached.

// File: rtl/spi_fm_pkg.sv
package spi_fm_pkg;
   localparam int WORD_W = 32;

   localparam logic [7:0] A_FMT  = 8'h00;
   localparam logic [7:0] A_MODE = 8'h04;
   localparam logic [7:0] A_CTRL = 8'h08;
   localparam logic [7:0] A_STAT = 8'h0C;
   localparam logic [7:0] A_IEN  = 8'h10;
   localparam logic [7:0] A_TXD  = 8'h14;
   localparam logic [7:0] A_RXD  = 8'h18;

   // control register bit positions
   localparam int B_SCLK_EN  = 15;
   localparam int B_FRAME_EN = 14;
   localparam int B_TX_EN    = 9;
   localparam int B_RX_EN    = 8;
   // status and interrupt enable bit positions
   localparam int B_TXEOF = 23;
   localparam int B_RXEOF = 7;
   // format register bit positions
   localparam int B_CPHA = 0;
   localparam int B_CPOL = 1;
   localparam int B_HIZ  = 2;
   localparam int B_LSB  = 24;

   // index of each enable inside the packed control vector
   localparam int CI_SCLK  = 3;
   localparam int CI_FRAME = 2;
   localparam int CI_TX    = 1;
   localparam int CI_RX    = 0;

   typedef enum logic [1:0] {ENG_IDLE, ENG_RUN, ENG_DONE} eng_state_t;
endpackage

// File: rtl/spi_fm_fifo.sv
module spi_fm_fifo #(
   parameter int W     = 32,
   parameter int DEPTH = 64
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] wdata,
   input  logic         pop,
   output logic [W-1:0] rdata,
   output logic         empty,
   output logic         full
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("spi_fm_fifo: DEPTH must be a power of two, at least 2");
      end
   endgenerate

   logic [W-1:0] mem [DEPTH];
   logic [AW-1:0] wptr, rptr;
   logic [AW:0]   count;
   logic          do_push, do_pop;

   assign empty   = (count == '0);
   assign full    = (count == (AW+1)'(DEPTH));
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign rdata   = mem[rptr];

   always_ff @(posedge clk) begin
      if (do_push) mem[wptr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else begin
         if (do_push) wptr <= wptr + 1'b1;
         if (do_pop)  rptr <= rptr + 1'b1;
         case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end
endmodule

// File: rtl/spi_fm_ctrlsync.sv
module spi_fm_ctrlsync #(
   parameter int STAGES = 2,
   parameter int W      = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] req,
   output logic [W-1:0] ack
);
   generate
      if (STAGES < 1) begin : g_bad_stages
         $error("spi_fm_ctrlsync: STAGES must be at least 1");
      end
   endgenerate

   logic [W-1:0] pipe [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      pipe[s] <= '0;
            else if (s == 0) pipe[s] <= req;
            else             pipe[s] <= pipe[(s > 0) ? s - 1 : 0];
         end
      end
   endgenerate

   assign ack = pipe[STAGES-1];
endmodule

// File: rtl/spi_fm_engine.sv
module spi_fm_engine
   import spi_fm_pkg::*;
#(
   parameter int CLK_HALF = 4,
   parameter int LEN_W    = 5,
   parameter int CNT_W    = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic              frame_en,
   input  logic              rx_en,
   input  logic [LEN_W-1:0]  len_m1,
   input  logic [CNT_W-1:0]  cnt_m1,
   input  logic              lsb_first,
   input  logic              cpol,
   input  logic              cpha,
   input  logic              tx_dis,
   input  logic [WORD_W-1:0] tx_word,
   input  logic              tx_empty,
   input  logic              miso,
   output logic              tx_pop,
   output logic              rx_push,
   output logic [WORD_W-1:0] rx_word,
   output logic              sclk,
   output logic              mosi,
   output logic              driving,
   output logic              busy,
   output logic              set_txeof,
   output logic              set_rxeof
);
   localparam int DW = (CLK_HALF > 1) ? $clog2(CLK_HALF) : 1;
   localparam logic [DW-1:0] HALF_LAST = DW'(CLK_HALF - 1);

   generate
      if (CLK_HALF < 1) begin : g_bad_half
         $error("spi_fm_engine: CLK_HALF must be at least 1");
      end
      if (LEN_W != 5) begin : g_bad_len
         $error("spi_fm_engine: LEN_W must be 5 for 32-bit entries");
      end
   endgenerate

   eng_state_t        state;
   logic [DW-1:0]     div_cnt;
   logic              half;
   logic [LEN_W-1:0]  bit_idx;
   logic [CNT_W-1:0]  word_idx;
   logic [WORD_W-1:0] sh_sr, rx_sr, rx_next, load_val;
   logic              tick, samp, shft, last_bit, last_word, start, load, tx_bit;

   always_comb begin
      tick      = (state == ENG_RUN) && go && (div_cnt == HALF_LAST);
      samp      = tick && !half;
      shft      = tick && half;
      last_bit  = (bit_idx == len_m1);
      last_word = (word_idx == cnt_m1);
      start     = (state == ENG_IDLE) && go;
      load      = start || (shft && last_bit && !last_word);
      tx_pop    = load && !tx_dis && !tx_empty;
      load_val  = (tx_dis || tx_empty) ? '0 : tx_word;
      rx_next   = lsb_first ? {miso, rx_sr[WORD_W-1:1]} : {rx_sr[WORD_W-2:0], miso};
      // MSB-first words collect at the bottom; lift them to the top
      rx_word   = lsb_first ? rx_next : (rx_next << (~len_m1));
      rx_push   = samp && last_bit && rx_en;
      set_rxeof = rx_push && last_word;
      set_txeof = shft && last_bit && last_word;
      tx_bit    = lsb_first ? sh_sr[~len_m1] : sh_sr[WORD_W-1];
      busy      = (state == ENG_RUN);
      driving   = busy && !tx_dis;
      mosi      = driving && tx_bit;
      sclk      = busy ? (cpol ^ (cpha ? ~half : half)) : cpol;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ENG_IDLE;
         div_cnt  <= '0;
         half     <= 1'b0;
         bit_idx  <= '0;
         word_idx <= '0;
         sh_sr    <= '0;
         rx_sr    <= '0;
      end else begin
         case (state)
            ENG_IDLE: begin
               if (start) begin
                  state    <= ENG_RUN;
                  div_cnt  <= '0;
                  half     <= 1'b0;
                  bit_idx  <= '0;
                  word_idx <= '0;
                  rx_sr    <= '0;
                  sh_sr    <= load_val;
               end
            end
            ENG_RUN: begin
               if (!go) begin
                  state <= ENG_IDLE;
               end else begin
                  div_cnt <= tick ? '0 : div_cnt + 1'b1;
                  if (samp) begin
                     half  <= 1'b1;
                     rx_sr <= last_bit ? '0 : rx_next;
                  end
                  if (shft) begin
                     half <= 1'b0;
                     if (last_bit) begin
                        bit_idx <= '0;
                        if (last_word) begin
                           state <= ENG_DONE;
                        end else begin
                           word_idx <= word_idx + 1'b1;
                           sh_sr    <= load_val;
                        end
                     end else begin
                        bit_idx <= bit_idx + 1'b1;
                        sh_sr   <= lsb_first ? (sh_sr >> 1) : (sh_sr << 1);
                     end
                  end
               end
            end
            default: begin
               if (!frame_en) state <= ENG_IDLE;
            end
         endcase
      end
   end
endmodule

// File: rtl/spi_frame_master.sv
module spi_frame_master
   import spi_fm_pkg::*;
#(
   parameter int FIFO_DEPTH  = 64,
   parameter int SYNC_STAGES = 2,
   parameter int CLK_HALF    = 4,
   parameter int ADDR_W      = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              irq,
   output logic              sclk,
   output logic              mosi,
   output logic              mosi_oe,
   input  logic              miso
);
   localparam int LEN_W = $clog2(WORD_W);
   localparam int CNT_W = 8;

   generate
      if (ADDR_W < 8) begin : g_bad_addr
         $error("spi_frame_master: ADDR_W must be at least 8");
      end
   endgenerate

   logic [7:0] reg_sel;
   assign reg_sel = bus_addr[7:0];

   // configuration
   logic              cfg_lsb, cfg_cpol, cfg_cpha, cfg_hiz, cfg_txdis;
   logic [LEN_W-1:0]  cfg_len_m1;
   logic [CNT_W-1:0]  cfg_cnt_m1;
   logic [3:0]        ctrl_req, ctrl_ack;
   logic              ien_tx, ien_rx, st_txeof, st_rxeof;

   // datapath links
   logic              tx_push, tx_pop, tx_empty, tx_full;
   logic              rx_push, rx_pop, rx_empty, rx_full;
   logic [WORD_W-1:0] tx_head, rx_head, rx_word;
   logic              eng_busy, eng_drive, set_txeof, set_rxeof, eng_go;

   logic wr_fmt, wr_mode, wr_ctrl, wr_stat, wr_ien;
   assign wr_fmt  = bus_wr && (reg_sel == A_FMT);
   assign wr_mode = bus_wr && (reg_sel == A_MODE);
   assign wr_ctrl = bus_wr && (reg_sel == A_CTRL);
   assign wr_stat = bus_wr && (reg_sel == A_STAT);
   assign wr_ien  = bus_wr && (reg_sel == A_IEN);
   assign tx_push = bus_wr && (reg_sel == A_TXD);
   assign rx_pop  = bus_rd && (reg_sel == A_RXD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_lsb    <= 1'b0;
         cfg_cpol   <= 1'b0;
         cfg_cpha   <= 1'b0;
         cfg_hiz    <= 1'b0;
         cfg_txdis  <= 1'b0;
         cfg_len_m1 <= LEN_W'(7);
         cfg_cnt_m1 <= '0;
         ctrl_req   <= '0;
         ien_tx     <= 1'b0;
         ien_rx     <= 1'b0;
         st_txeof   <= 1'b0;
         st_rxeof   <= 1'b0;
      end else begin
         if (wr_fmt) begin
            cfg_lsb  <= bus_wdata[B_LSB];
            cfg_cpol <= bus_wdata[B_CPOL];
            cfg_cpha <= bus_wdata[B_CPHA];
            cfg_hiz  <= bus_wdata[B_HIZ];
         end
         if (wr_mode) begin
            cfg_len_m1 <= bus_wdata[24 +: LEN_W];
            cfg_cnt_m1 <= bus_wdata[16 +: CNT_W];
            cfg_txdis  <= bus_wdata[0];
         end
         if (wr_ctrl) begin
            ctrl_req[CI_SCLK]  <= bus_wdata[B_SCLK_EN];
            ctrl_req[CI_FRAME] <= bus_wdata[B_FRAME_EN];
            ctrl_req[CI_TX]    <= bus_wdata[B_TX_EN];
            ctrl_req[CI_RX]    <= bus_wdata[B_RX_EN];
         end
         if (wr_ien) begin
            ien_tx <= bus_wdata[B_TXEOF];
            ien_rx <= bus_wdata[B_RXEOF];
         end
         st_txeof <= set_txeof | (st_txeof & ~(wr_stat & bus_wdata[B_TXEOF]));
         st_rxeof <= set_rxeof | (st_rxeof & ~(wr_stat & bus_wdata[B_RXEOF]));
      end
   end

   spi_fm_ctrlsync #(.STAGES(SYNC_STAGES), .W(4)) u_sync (
      .clk(clk), .rst_n(rst_n), .req(ctrl_req), .ack(ctrl_ack)
   );

   spi_fm_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_txq (
      .clk(clk), .rst_n(rst_n), .push(tx_push), .wdata(bus_wdata),
      .pop(tx_pop), .rdata(tx_head), .empty(tx_empty), .full(tx_full)
   );

   spi_fm_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_rxq (
      .clk(clk), .rst_n(rst_n), .push(rx_push), .wdata(rx_word),
      .pop(rx_pop), .rdata(rx_head), .empty(rx_empty), .full(rx_full)
   );

   assign eng_go = ctrl_ack[CI_SCLK] & ctrl_ack[CI_TX] & ctrl_ack[CI_FRAME];

   spi_fm_engine #(.CLK_HALF(CLK_HALF), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_eng (
      .clk(clk), .rst_n(rst_n), .go(eng_go), .frame_en(ctrl_ack[CI_FRAME]),
      .rx_en(ctrl_ack[CI_RX]), .len_m1(cfg_len_m1), .cnt_m1(cfg_cnt_m1),
      .lsb_first(cfg_lsb), .cpol(cfg_cpol), .cpha(cfg_cpha), .tx_dis(cfg_txdis),
      .tx_word(tx_head), .tx_empty(tx_empty), .miso(miso),
      .tx_pop(tx_pop), .rx_push(rx_push), .rx_word(rx_word),
      .sclk(sclk), .mosi(mosi), .driving(eng_drive), .busy(eng_busy),
      .set_txeof(set_txeof), .set_rxeof(set_rxeof)
   );

   assign mosi_oe = cfg_hiz ? eng_drive : 1'b1;
   assign irq     = (st_txeof & ien_tx) | (st_rxeof & ien_rx);

   always_comb begin
      bus_rdata = '0;
      case (reg_sel)
         A_FMT: begin
            bus_rdata[B_LSB]  = cfg_lsb;
            bus_rdata[B_CPOL] = cfg_cpol;
            bus_rdata[B_CPHA] = cfg_cpha;
            bus_rdata[B_HIZ]  = cfg_hiz;
         end
         A_MODE: begin
            bus_rdata[24 +: LEN_W] = cfg_len_m1;
            bus_rdata[16 +: CNT_W] = cfg_cnt_m1;
            bus_rdata[0]           = cfg_txdis;
         end
         A_CTRL: begin
            bus_rdata[B_SCLK_EN]  = ctrl_ack[CI_SCLK];
            bus_rdata[B_FRAME_EN] = ctrl_ack[CI_FRAME];
            bus_rdata[B_TX_EN]    = ctrl_ack[CI_TX];
            bus_rdata[B_RX_EN]    = ctrl_ack[CI_RX];
         end
         A_STAT: begin
            bus_rdata[B_TXEOF] = st_txeof;
            bus_rdata[B_RXEOF] = st_rxeof;
         end
         A_IEN: begin
            bus_rdata[B_TXEOF] = ien_tx;
            bus_rdata[B_RXEOF] = ien_rx;
         end
         A_RXD:   bus_rdata = rx_empty ? '0 : rx_head;
         default: bus_rdata = '0;
      endcase
   end

   logic fifo_flags_unused;
   assign fifo_flags_unused = ^{tx_full, rx_full, bus_addr};
endmodule

// File: rtl/spi_fm_chk.sv
module spi_fm_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       eng_busy,
   input logic [2:0] go_acks,
   input logic       sclk,
   input logic       cfg_cpol,
   input logic       cfg_hiz,
   input logic       mosi_oe,
   input logic       st_txeof,
   input logic       st_rxeof,
   input logic       irq
);
   // R2
   start_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(eng_busy) |-> $past(&go_acks));

   // R8
   sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !eng_busy |-> (sclk == cfg_cpol));

   // R11
   hiz_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_hiz && !eng_busy) |-> !mosi_oe);

   // R9
   txeof_after_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(st_txeof) |-> $past(eng_busy));

   // R10
   irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (st_txeof || st_rxeof));
endmodule

bind spi_frame_master spi_fm_chk u_chk (
   .clk(clk), .rst_n(rst_n), .eng_busy(eng_busy),
   .go_acks({ctrl_ack[3], ctrl_ack[2], ctrl_ack[1]}),
   .sclk(sclk), .cfg_cpol(cfg_cpol), .cfg_hiz(cfg_hiz), .mosi_oe(mosi_oe),
   .st_txeof(st_txeof), .st_rxeof(st_rxeof), .irq(irq)
);

// File: tb/sim_spi_frame_master.sv
module sim_spi_frame_master;
   import spi_fm_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0, bus_rdata;
   logic        irq, sclk, mosi, mosi_oe;
   logic        miso = 1'b0;

   always #5 clk = ~clk;

   spi_frame_master #(.FIFO_DEPTH(16), .SYNC_STAGES(2), .CLK_HALF(2), .ADDR_W(8)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .sclk(sclk),
      .mosi(mosi), .mosi_oe(mosi_oe), .miso(miso)
   );

   int n_chk = 0, n_fail = 0;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // slave model
   logic        slv_on = 1'b0, samp_lvl = 1'b0, exp_oe = 1'b1;
   int          ncap = 0, oe_bad = 0;
   logic        cap   [0:1023];
   logic        mbits [0:1023];
   logic [31:0] txw   [0:15];

   always @(sclk) begin
      if (slv_on && sclk === samp_lvl && ncap < 1023) begin
         cap[ncap] = mosi;
         if (mosi_oe !== exp_oe) oe_bad++;
         ncap++;
         miso = mbits[ncap];
      end
   end

   task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic ctrl_set(input int pos, input logic val);
      logic [31:0] v;
      bus_read(A_CTRL, v);
      v[pos] = val;
      bus_write(A_CTRL, v);
      for (int k = 0; k < 20; k++) begin
         bus_read(A_CTRL, v);
         if (v[pos] == val) break;
      end
   endtask

   function automatic logic [31:0] exp_rx(input int w, input int len, input bit lsb);
      logic [31:0] e = '0;
      for (int i = 0; i < len; i++) begin
         if (lsb) e[32-len+i] = mbits[w*len+i];
         else     e[31-i]     = mbits[w*len+i];
      end
      return e;
   endfunction

   task automatic run_frame(input int len, input int cnt, input bit lsb, input bit cpol,
                            input bit cpha, input bit txdis, input bit rxen, input bit hiz,
                            input bit push, input bit [1:0] ien);
      logic [31:0] v, mode_v;
      int mism, seen_rx_first, keep;
      bus_write(A_FMT, (32'(lsb) << B_LSB) | (32'(hiz) << B_HIZ) |
                       (32'(cpol) << B_CPOL) | (32'(cpha) << B_CPHA));
      mode_v = (32'(len - 1) << 24) | (32'(cnt - 1) << 16) | 32'(txdis);
      bus_write(A_MODE, mode_v);
      bus_write(A_IEN, (32'(ien[1]) << B_TXEOF) | (32'(ien[0]) << B_RXEOF));
      if (push) begin
         for (int w = 0; w < cnt; w++) begin
            txw[w] = $urandom;
            bus_write(A_TXD, txw[w]);
         end
      end
      for (int i = 0; i < 1024; i++) mbits[i] = 1'($urandom);
      ncap = 0; oe_bad = 0;
      samp_lvl = cpha ? cpol : ~cpol;
      exp_oe = hiz ? !txdis : 1'b1;
      miso = mbits[0];
      slv_on = 1'b1;
      ctrl_set(B_SCLK_EN, 1'b1);
      if (rxen) ctrl_set(B_RX_EN, 1'b1);
      ctrl_set(B_TX_EN, 1'b1);
      ctrl_set(B_FRAME_EN, 1'b1);
      // poll status every cycle through the combinational read path
      seen_rx_first = 0;
      @(negedge clk);
      bus_addr = A_STAT;
      for (int k = 0; k < 6000; k++) begin
         @(negedge clk); #1;
         if (bus_rdata[B_RXEOF] && !bus_rdata[B_TXEOF]) seen_rx_first = 1;
         if (bus_rdata[B_TXEOF]) break;
      end
      // R9: receive flag precedes transmit flag
      if (rxen) check("R9 rx flag before tx flag", 32'(seen_rx_first), 32'd1);
      keep = ncap;
      repeat (40) @(negedge clk);
      // R12: no restart while frame start stays set
      check("R12 no second frame", 32'(ncap), 32'(keep));
      check("R8 sclk idle level", 32'(sclk), 32'(cpol));
      slv_on = 1'b0;
      check("R3 sampling edge count", 32'(keep), 32'(len * cnt));
      mism = 0;
      for (int w = 0; w < cnt; w++) begin
         for (int i = 0; i < len; i++) begin
            logic eb;
            eb = txdis ? 1'b0 : (lsb ? txw[w][32-len+i] : txw[w][31-i]);
            if (cap[w*len+i] !== eb) mism++;
         end
      end
      if (txdis)    check("R6 mosi low when tx data disabled", 32'(mism), 32'd0);
      else if (lsb) check("R4 LSB-first mosi stream", 32'(mism), 32'd0);
      else          check("R3 MSB-first mosi stream", 32'(mism), 32'd0);
      check("R11 output enable during frame", 32'(oe_bad), 32'd0);
      check("R10 irq after frame", 32'(irq), 32'(ien[1] | (ien[0] & rxen)));
      bus_read(A_STAT, v);
      check(rxen ? "R9 status flags" : "R7 no rx flag when rx off", v,
            (32'd1 << B_TXEOF) | (32'(rxen) << B_RXEOF));
      bus_write(A_STAT, (32'd1 << B_TXEOF) | (32'd1 << B_RXEOF));
      bus_read(A_STAT, v);
      check("R9 write-one clear", v, 32'd0);
      check("R10 irq drops after clear", 32'(irq), 32'd0);
      if (rxen) begin
         mism = 0;
         for (int w = 0; w < cnt; w++) begin
            bus_read(A_RXD, v);
            if (v !== exp_rx(w, len, lsb)) begin
               mism++;
               $display("  word %0d got %h want %h", w, v, exp_rx(w, len, lsb));
            end
         end
         check("R5 R7 received words", 32'(mism), 32'd0);
      end
      ctrl_set(B_FRAME_EN, 1'b0);
      ctrl_set(B_TX_EN, 1'b0);
      if (rxen) ctrl_set(B_RX_EN, 1'b0);
      ctrl_set(B_SCLK_EN, 1'b0);
      check("R11 idle output enable", 32'(mosi_oe), 32'(!hiz));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic [31:0] v;
      void'($urandom(32'h5eed_0c1d));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state
      bus_read(A_CTRL, v); check("R1 reset control", v, 32'd0);
      bus_read(A_STAT, v); check("R9 reset status", v, 32'd0);
      check("R10 reset irq", 32'(irq), 32'd0);
      check("R8 reset sclk", 32'(sclk), 32'd0);
      check("R11 reset output enable", 32'(mosi_oe), 32'd1);

      // R1: readback lags the write by the synchronizer depth
      bus_write(A_CTRL, 32'd1 << B_SCLK_EN);
      #1 check("R1 readback still old", bus_rdata, 32'd0);
      @(posedge clk); @(posedge clk); #1;
      check("R1 readback now new", bus_rdata, 32'd1 << B_SCLK_EN);

      // R2: clock and transmit enables without frame start
      bus_write(A_FMT, 32'd1 << B_CPOL);
      ctrl_set(B_TX_EN, 1'b1);
      repeat (40) @(negedge clk);
      check("R2 sclk idle without frame start", 32'(sclk), 32'd1);
      bus_read(A_STAT, v); check("R2 no status without frame start", v, 32'd0);
      ctrl_set(B_TX_EN, 1'b0);
      ctrl_set(B_SCLK_EN, 1'b0);

      // directed corners
      run_frame(8, 1, 0, 0, 0, 0, 1, 0, 1, 2'b11);
      run_frame(32, 16, 1, 1, 1, 0, 1, 1, 1, 2'b10);
      // R6: dummy data, FIFO untouched; the next frame sends the loaded words
      run_frame(12, 2, 0, 0, 1, 1, 0, 1, 1, 2'b01);
      run_frame(12, 2, 0, 0, 1, 0, 1, 0, 0, 2'b01);
      // R7: receive off, then receive on; first read belongs to second frame
      run_frame(16, 3, 1, 1, 0, 0, 0, 0, 1, 2'b00);
      run_frame(16, 2, 0, 1, 0, 0, 1, 0, 1, 2'b01);

      // constrained random frames
      for (int n = 0; n < 10; n++) begin
         int len, cnt;
         len = 8 + int'($urandom % 25);
         cnt = 1 + int'($urandom % 16);
         run_frame(len, cnt, 1'($urandom), 1'($urandom), 1'($urandom), 1'b0,
                   1'($urandom), 1'($urandom), 1'b1, 2'($urandom));
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule